// File: doc/BRIEF.md
# Polled Byte Transfer Buffer

This block lets a host processor carry out the data phase of a disk-controller transfer one byte at a time, by polling, when no bus-mastering transfer is available. Before each phase the controller side loads a byte count with a start strobe. For a phase in which the host reads, the controller side also fills the buffer through its own load port. The host then moves bytes through an eight-address data window. Every address in that window reaches the same buffer position, and the position advances after each access. A status register tells the host whether bytes are still outstanding and whether an interrupt is pending.

When the last byte of the phase has been moved, a one-cycle completion pulse goes back to the controller side. After a host-write phase, the bytes the host collected can be read on the controller's read port. Host addresses below the data window are forwarded to the controller's register port. Writing the status address stores a control byte and pulses the controller's transfer enable.

Top module: `pio_xfer_top`

## Requirements
- R1: Host reads and writes at any of the addresses 0x20 to 0x27 all reach the buffer at the current position, and the position then advances by one.
- R2: A host write to the data window stores its byte only while the position is below the loaded count. Otherwise the write has no effect: the buffer contents and the position are unchanged.
- R3: A host read of the data window returns the buffered byte at the current position while that position is below the count. Otherwise it returns 0x00 and the position does not move. A count of zero gives an exhausted transfer at once.
- R4: The host access that moves the position up to the count causes `ctl_done` to be high for exactly the following cycle. After a write phase, `ctl_rd_data` then shows the collected bytes at their positions.
- R5: A host read of address 0x40 returns a byte in which bit 6 is chip_irq OR the board flag, and bit 7 is set while the position is below the count. Bits 5 to 0 are zero. `host_irq` equals bit 6.
- R6: A status read clears the board flag and leaves chip_irq untouched. A `board_irq_set` pulse in the same cycle as a status read keeps the flag set.
- R7: A host write to address 0x40 stores its byte in `ctrl_q` and raises `ctl_dma_en` for exactly one cycle.
- R8: `ctl_start` loads `ctl_size` as the new count (clamped to DEPTH) and returns the position to zero. `ctl_ld_we` writes `ctl_ld_data` into the buffer at `ctl_ld_addr`.
- R9: Host accesses at addresses 0x00 to 0x1F raise `reg_rd`/`reg_wr` in the same cycle, with `reg_addr` set to the low five address bits and `reg_wdata` set to the host byte. A read returns `reg_rdata`.
- R10: Host accesses at any other address read 0x00 and change neither the buffer, the position, the board flag nor `ctrl_q`.
- R11: After reset, the position and count are zero, the board flag and `ctrl_q` are zero, and `ctl_done` and `ctl_dma_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host byte address within the I/O space |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| reg_rd | output | 1 | Forwarded controller register read |
| reg_wr | output | 1 | Forwarded controller register write |
| reg_addr | output | 5 | Forwarded controller register index |
| reg_wdata | output | 8 | Forwarded controller register write byte |
| reg_rdata | input | 8 | Controller register read byte |
| ctl_start | input | 1 | Start of a phase: load count, clear position |
| ctl_size | input | 10 | Byte count of the phase |
| ctl_ld_we | input | 1 | Buffer load strobe |
| ctl_ld_addr | input | 9 | Buffer load position |
| ctl_ld_data | input | 8 | Buffer load byte |
| ctl_rd_addr | input | 9 | Controller read-back position |
| ctl_rd_data | output | 8 | Controller read-back byte |
| ctl_done | output | 1 | One-cycle completion pulse |
| ctl_dma_en | output | 1 | One-cycle transfer-enable pulse |
| ctrl_q | output | 8 | Last control byte written by the host |
| chip_irq | input | 1 | Controller interrupt level |
| board_irq_set | input | 1 | Pulse that sets the board interrupt flag |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
Random phases of random length in both directions are run, each with random addresses inside the window. This separates a buffer that follows the position from one indexed by the address. Every phase overruns the count by a few accesses, which shows that the position freezes, that exhausted reads give zero and that late writes are dropped. It also places the completion pulse on the exact access that reaches the count. Directed cases cover a zero count, interrupt set and clear landing in the same cycle, forwarded register accesses, and stray addresses made during a live phase. Stray accesses in a live phase would show up as a position that skips.

// File: rtl/pio_xfer_pkg.sv
package pio_xfer_pkg;
   localparam logic [7:0] WIN_BASE  = 8'h20;
   localparam int         WIN_SPAN  = 8;
   localparam logic [7:0] STAT_ADDR = 8'h40;
   localparam logic [7:0] PASS_LIM  = 8'h20;

   typedef enum logic [1:0] {
      RGN_PASS = 2'd0,
      RGN_WIN  = 2'd1,
      RGN_STAT = 2'd2,
      RGN_NONE = 2'd3
   } region_e;

   function automatic region_e decode(input logic [7:0] a);
      if (a < PASS_LIM)                                          return RGN_PASS;
      else if (a >= WIN_BASE && a < WIN_BASE + 8'(WIN_SPAN))     return RGN_WIN;
      else if (a == STAT_ADDR)                                   return RGN_STAT;
      else                                                       return RGN_NONE;
   endfunction
endpackage

// File: rtl/pio_xfer_mem.sv
module pio_xfer_mem #(
   parameter int DEPTH = 512,
   parameter int DW    = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             hw_we,
   input  logic [IDX_W-1:0] hw_addr,
   input  logic [DW-1:0]    hw_data,
   input  logic             ld_we,
   input  logic [IDX_W-1:0] ld_addr,
   input  logic [DW-1:0]    ld_data,
   input  logic [IDX_W-1:0] ra_addr,
   output logic [DW-1:0]    ra_data,
   input  logic [IDX_W-1:0] rb_addr,
   output logic [DW-1:0]    rb_data
);
   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (hw_we) store[hw_addr] <= hw_data;
      if (ld_we) store[ld_addr] <= ld_data;
   end

   assign ra_data = store[ra_addr];
   assign rb_data = store[rb_addr];
endmodule

// File: rtl/pio_xfer_ctr.sv
module pio_xfer_ctr #(
   parameter int DEPTH = 512,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] size_in,
   input  logic             step,
   output logic [IDX_W-1:0] pos,
   output logic             pending,
   output logic             done
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] off_q, size_q;
   logic             done_q;
   logic [CNT_W-1:0] size_clamped;

   assign size_clamped = (size_in > DEPTH_C) ? DEPTH_C : size_in;
   assign pending      = off_q < size_q;
   assign pos          = off_q[IDX_W-1:0];
   assign done         = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q  <= '0;
         size_q <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         off_q  <= '0;
         size_q <= size_clamped;
         done_q <= 1'b0;
      end else begin
         done_q <= step && pending && (off_q + 1'b1 == size_q);
         if (step && pending) off_q <= off_q + 1'b1;
      end
   end

   a_r2_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= size_q);
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r3_hold_when_dry: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !pending && !start) |=> $stable(off_q));
   a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (off_q == '0));
endmodule

// File: rtl/pio_xfer_stat.sv
module pio_xfer_stat #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chip_irq,
   input  logic          board_set,
   input  logic          st_rd,
   input  logic          st_wr,
   input  logic [DW-1:0] wdata,
   input  logic          pending,
   output logic [DW-1:0] status,
   output logic [DW-1:0] ctrl_q,
   output logic          dma_en,
   output logic          host_irq
);
   logic flag_q, en_q;
   logic [DW-1:0] ctrl_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         en_q   <= 1'b0;
         ctrl_r <= '0;
      end else begin
         if (board_set)  flag_q <= 1'b1;
         else if (st_rd) flag_q <= 1'b0;
         en_q <= st_wr;
         if (st_wr) ctrl_r <= wdata;
      end
   end

   assign host_irq = chip_irq | flag_q;
   always_comb begin
      status    = '0;
      status[6] = host_irq;
      status[7] = pending;
   end
   assign ctrl_q = ctrl_r;
   assign dma_en = en_q;

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !board_set) |=> !flag_q);
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      board_set |=> flag_q);
   a_r7_enable_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |=> dma_en);
   a_r7_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr |=> !dma_en);
endmodule

// File: rtl/pio_xfer_top.sv
module pio_xfer_top
   import pio_xfer_pkg::*;
#(
   parameter int DEPTH     = 512,
   parameter bit RDATA_REG = 1'b0,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       host_addr,
   input  logic             host_rd,
   input  logic             host_wr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             reg_rd,
   output logic             reg_wr,
   output logic [4:0]       reg_addr,
   output logic [7:0]       reg_wdata,
   input  logic [7:0]       reg_rdata,
   input  logic             ctl_start,
   input  logic [CNT_W-1:0] ctl_size,
   input  logic             ctl_ld_we,
   input  logic [IDX_W-1:0] ctl_ld_addr,
   input  logic [7:0]       ctl_ld_data,
   input  logic [IDX_W-1:0] ctl_rd_addr,
   output logic [7:0]       ctl_rd_data,
   output logic             ctl_done,
   output logic             ctl_dma_en,
   output logic [7:0]       ctrl_q,
   input  logic             chip_irq,
   input  logic             board_irq_set,
   output logic             host_irq
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("pio_xfer_top: DEPTH must be at least 2");
   end

   region_e    rgn;
   logic       in_win, in_stat, in_pass;
   logic       step, pending;
   logic [IDX_W-1:0] pos;
   logic [7:0] buf_byte, status, rd_mux;

   assign rgn     = decode(host_addr);
   assign in_win  = (rgn == RGN_WIN);
   assign in_stat = (rgn == RGN_STAT);
   assign in_pass = (rgn == RGN_PASS);
   assign step    = in_win && (host_rd || host_wr);

   assign reg_rd    = host_rd && in_pass;
   assign reg_wr    = host_wr && in_pass;
   assign reg_addr  = host_addr[4:0];
   assign reg_wdata = host_wdata;

   pio_xfer_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(ctl_start), .size_in(ctl_size),
      .step(step), .pos(pos), .pending(pending), .done(ctl_done)
   );

   pio_xfer_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
      .clk(clk),
      .hw_we(host_wr && in_win && pending && !ctl_start), .hw_addr(pos), .hw_data(host_wdata),
      .ld_we(ctl_ld_we), .ld_addr(ctl_ld_addr), .ld_data(ctl_ld_data),
      .ra_addr(pos), .ra_data(buf_byte),
      .rb_addr(ctl_rd_addr), .rb_data(ctl_rd_data)
   );

   pio_xfer_stat #(.DW(8)) u_stat (
      .clk(clk), .rst_n(rst_n), .chip_irq(chip_irq), .board_set(board_irq_set),
      .st_rd(host_rd && in_stat), .st_wr(host_wr && in_stat), .wdata(host_wdata),
      .pending(pending), .status(status), .ctrl_q(ctrl_q), .dma_en(ctl_dma_en),
      .host_irq(host_irq)
   );

   always_comb begin
      unique case (rgn)
         RGN_PASS: rd_mux = reg_rdata;
         RGN_WIN:  rd_mux = pending ? buf_byte : 8'h00;
         RGN_STAT: rd_mux = status;
         default:  rd_mux = 8'h00;
      endcase
   end

   if (RDATA_REG) begin : g_rdata_reg
      logic [7:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else if (host_rd) rdata_q <= rd_mux;
      end
      assign host_rdata = rdata_q;
   end else begin : g_rdata_comb
      assign host_rdata = rd_mux;
      a_r3_dry_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (host_rd && in_win && !pending) |-> (host_rdata == 8'h00));
      a_r10_stray_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (host_rd && rgn == RGN_NONE) |-> (host_rdata == 8'h00));
   end

   a_r10_stray_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && rgn == RGN_NONE) |=> $stable(ctrl_q));
   a_r9_pass_only_low: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd || reg_wr) |-> (host_addr < 8'h20));
endmodule

// File: tb/pio_xfer_top_tb.sv
`timescale 1ns/1ps
module pio_xfer_top_tb;
   localparam int DEPTH = 512;

   logic clk = 0, rst_n = 0;
   logic [7:0] host_addr = 0, host_wdata = 0, reg_rdata = 0, ctl_ld_data = 0;
   logic host_rd = 0, host_wr = 0, ctl_start = 0, ctl_ld_we = 0, chip_irq = 0, board_irq_set = 0;
   logic [9:0] ctl_size = 0;
   logic [8:0] ctl_ld_addr = 0, ctl_rd_addr = 0;
   logic [7:0] host_rdata, reg_wdata, ctl_rd_data, ctrl_q;
   logic [4:0] reg_addr;
   logic reg_rd, reg_wr, ctl_done, ctl_dma_en, host_irq;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] mdl [DEPTH];

   always #4 clk = ~clk;

   pio_xfer_top u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_start(ctl_start),
      .ctl_size(ctl_size), .ctl_ld_we(ctl_ld_we), .ctl_ld_addr(ctl_ld_addr),
      .ctl_ld_data(ctl_ld_data), .ctl_rd_addr(ctl_rd_addr), .ctl_rd_data(ctl_rd_data),
      .ctl_done(ctl_done), .ctl_dma_en(ctl_dma_en), .ctrl_q(ctrl_q), .chip_irq(chip_irq),
      .board_irq_set(board_irq_set), .host_irq(host_irq)
   );

   function automatic logic [7:0] exp_status(input logic irq, input logic pend);
      return {pend, irq, 6'b0};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hacc(input logic wr, input logic [7:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output logic dn);
      @(negedge clk);
      host_addr = a; host_wr = wr; host_rd = !wr; host_wdata = d;
      #1 rd = host_rdata;
      @(negedge clk);
      host_wr = 0; host_rd = 0;
      dn = ctl_done;
   endtask

   task automatic begin_phase(input int sz);
      @(negedge clk); ctl_start = 1; ctl_size = 10'(sz);
      @(negedge clk); ctl_start = 0;
   endtask

   task automatic load(input int idx, input logic [7:0] d);
      @(negedge clk); ctl_ld_we = 1; ctl_ld_addr = 9'(idx); ctl_ld_data = d;
      @(negedge clk); ctl_ld_we = 0;
      mdl[idx] = d;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         chk(0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r; logic dn;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(ctl_done == 0 && ctl_dma_en == 0, "R11 strobes idle", {ctl_done, ctl_dma_en}, 0);
      chk(ctrl_q == 0, "R11 ctrl_q", ctrl_q, 0);
      hacc(0, 8'h40, 0, r, dn);
      chk(r == 8'h00, "R11 status after reset", r, 0);

      for (int i = 0; i < DEPTH; i++) load(i, 8'($urandom));

      // R9 pass-through
      @(negedge clk); reg_rdata = 8'h5A; host_addr = 8'h05; host_rd = 1;
      #1 chk(host_rdata == 8'h5A && reg_rd && !reg_wr && reg_addr == 5'd5, "R9 read forward",
             host_rdata, 8'h5A);
      @(negedge clk); host_rd = 0; host_wr = 1; host_addr = 8'h1F; host_wdata = 8'hA7;
      #1 chk(reg_wr && !reg_rd && reg_addr == 5'h1F && reg_wdata == 8'hA7, "R9 write forward",
             {reg_wr, reg_addr}, {1'b1, 5'h1F});
      @(negedge clk); host_wr = 0;

      // R7 control write
      hacc(1, 8'h40, 8'hC3, r, dn);
      chk(ctrl_q == 8'hC3, "R7 ctrl stored", ctrl_q, 8'hC3);
      chk(ctl_dma_en == 1, "R7 enable pulse high", ctl_dma_en, 1);
      @(negedge clk);
      chk(ctl_dma_en == 0, "R7 enable pulse one cycle", ctl_dma_en, 0);

      // R5 / R6 interrupts
      @(negedge clk); board_irq_set = 1; @(negedge clk); board_irq_set = 0;
      chk(host_irq == 1, "R5 host_irq from board flag", host_irq, 1);
      hacc(0, 8'h40, 0, r, dn);
      chk(r == exp_status(1, 0), "R5 status board irq", r, exp_status(1, 0));
      hacc(0, 8'h40, 0, r, dn);
      chk(r == exp_status(0, 0), "R6 board flag cleared by read", r, exp_status(0, 0));
      chip_irq = 1;
      hacc(0, 8'h40, 0, r, dn);
      hacc(0, 8'h40, 0, r, dn);
      chk(r == exp_status(1, 0), "R6 chip irq not cleared", r, exp_status(1, 0));
      chip_irq = 0;
      @(negedge clk); board_irq_set = 1; host_addr = 8'h40; host_rd = 1;
      @(negedge clk); board_irq_set = 0; host_rd = 0;
      hacc(0, 8'h40, 0, r, dn);
      chk(r == exp_status(1, 0), "R6 set wins over clear", r, exp_status(1, 0));

      // R3 zero count
      begin_phase(0);
      hacc(0, 8'h40, 0, r, dn);
      chk(r == 8'h00, "R3 zero count not pending", r, 0);
      hacc(0, 8'h22, 0, r, dn);
      chk(r == 8'h00 && dn == 0, "R3 zero count read", r, 0);

      // R1 R2 R3 R4 R8 random phases
      for (int ph = 0; ph < 14; ph++) begin
         int sz; bit wrp; int moff;
         sz = $urandom_range(1, 24);
         wrp = $urandom_range(0, 1);
         begin_phase(sz);
         moff = 0;
         hacc(0, 8'h40, 0, r, dn);
         chk(r == exp_status(0, 1), "R8 start makes pending", r, exp_status(0, 1));
         if (!wrp) for (int i = 0; i < sz; i++) load(i, 8'($urandom));
         for (int k = 0; k < sz + 3; k++) begin
            logic [7:0] a, d, e; bit edone;
            a = 8'h20 + 8'($urandom_range(0, 7));
            d = 8'($urandom);
            edone = (moff + 1 == sz);
            e = (moff < sz) ? mdl[moff] : 8'h00;
            hacc(wrp, a, d, r, dn);
            if (wrp) begin
               if (moff < sz) mdl[moff] = d;
            end else
               chk(r == e, moff < sz ? "R1 window read byte" : "R3 exhausted read zero", r, e);
            chk(dn == edone, "R4 done pulse", dn, edone);
            if (moff < sz) moff++;
         end
         if (wrp) for (int i = 0; i < sz + 3; i++) begin
            @(negedge clk); ctl_rd_addr = 9'(i);
            #1 chk(ctl_rd_data == mdl[i], i < sz ? "R4 collected byte" : "R2 late write dropped",
                   ctl_rd_data, mdl[i]);
         end
      end

      // R10 stray addresses during a live phase
      begin_phase(2);
      for (int i = 0; i < 2; i++) load(i, 8'(8'h60 + i));
      hacc(1, 8'h33, 8'hEE, r, dn);
      hacc(1, 8'h41, 8'h11, r, dn);
      hacc(0, 8'h60, 0, r, dn);
      chk(r == 8'h00, "R10 stray read zero", r, 0);
      chk(ctrl_q == 8'hC3, "R10 ctrl unchanged", ctrl_q, 8'hC3);
      hacc(0, 8'h27, 0, r, dn);
      chk(r == 8'h60, "R10 position unchanged", r, 8'h60);
      hacc(0, 8'h20, 0, r, dn);
      chk(r == 8'h61 && dn == 1, "R4 done on last read", r, 8'h61);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule